// File: doc/BRIEF.md
# USB Host Endpoint-0 Control Transaction Sequencer

This block drives the data and status stages of a control transfer on endpoint 0 of a USB host. It works at the token and handshake level. Software arms a transaction by setting request bits in an 8-bit control/status register. The sequencer then asks an abstract packet engine to send one of two things: an OUT token followed by a DATA0/DATA1 packet, or an IN token. When the packet engine returns a reply code, the sequencer classifies it.

Each reply either finishes the transaction or triggers a retry. A finished transaction updates the sticky status bits and raises a one-cycle interrupt pulse. There are two separate ways to give up:
- **Errors:** a counter of invalid or missing replies gives up after three in a row.
- **NAKs:** a programmable limit on consecutive NAK replies sets a timeout flag and halts the endpoint by clearing the armed request.

Line coding, CRC and the PHY belong to the packet engine.

Top module: `usb_ep0_ctrl_seq`

## Requirements
- R1: After reset the register reads 0x00, `irq` and `pe_start` are low, and the first OUT packet is sent as DATA1.
- R2: If bit 1 (transmit ready) is set and no transaction is in flight, `pe_start` pulses for one cycle with `pe_in`=0. `pe_start` then stays low until the engine's `pe_done` returns.
- R3: An ACK reply (code 0) to an OUT transaction clears bit 1 and pulses `irq` in the cycle after `pe_done`.
- R4: On OUT packets, `pe_data1` starts at 1 after reset or after a write with bit 3 set. It flips after every ACKed OUT packet. On IN tokens `pe_data1` is always 1. Bit 3 always reads 0.
- R5: A STALL reply (code 2) sets bit 2, clears the armed request (bit 1 for OUT, bit 5 for IN) and pulses `irq`.
- R6: NAK replies (code 1) are counted against `nak_limit`. If the limit L is not zero, the L-th consecutive NAK sets bit 7, clears the armed request and pulses `irq`. Earlier NAKs cause a retry start with no `irq`. When L is 0, NAKs never time out.
- R7: The following count as no valid reply: code 4 (timeout), codes 5 to 7, DATA (code 3) on an OUT, and ACK on an IN. The third such reply in a row sets bit 4, clears the armed request and pulses `irq`. The first and second cause a retry. Any ACK, DATA, STALL or NAK reply restarts this count.
- R8: The NAK count restarts on any reply that is not a NAK.
- R9: With bits 5 (request) and 6 (status) both set, the block starts an IN token (`pe_in`=1). A DATA reply sets bit 0, clears bit 5, leaves bit 6 set and pulses `irq`.
- R10: Status bits 0, 2, 4 and 7 are sticky:
  - writing 0 clears them;
  - writing 1 has no effect;
  - a hardware set or clear in the same cycle as a software write takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_wr | input | 1 | Register write strobe |
| csr_wdata | input | 8 | Register write data |
| nak_limit | input | NAK_W | Consecutive-NAK limit, 0 disables |
| csr_rdata | output | 8 | Register read value |
| pe_start | output | 1 | One-cycle request to the packet engine |
| pe_in | output | 1 | Token type: 1 IN, 0 OUT |
| pe_data1 | output | 1 | Data PID: 1 DATA1, 0 DATA0 |
| pe_done | input | 1 | One-cycle reply-valid pulse |
| pe_reply | input | 3 | Reply code |
| irq | output | 1 | Endpoint-0 interrupt pulse |

## Verification
If the NAK or error counter is left in a wrong state, the give-up point moves. The `irq` pulse and bit 7 or bit 4 then appear one reply early or late, or only after the next reply that should have reset the count. A wrong toggle register shows on `pe_data1` at the very next OUT start. A wrong busy flag shows as a missing or repeated `pe_start` in the cycle after a reply.

// File: rtl/usb_ep0_ctrl_seq.sv
module usb_ep0_ctrl_seq #(
  parameter int NAK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [7:0]       csr_wdata,
  input  logic [NAK_W-1:0] nak_limit,
  output logic [7:0]       csr_rdata,
  output logic             pe_start,
  output logic             pe_in,
  output logic             pe_data1,
  input  logic             pe_done,
  input  logic [2:0]       pe_reply,
  output logic             irq
);
  localparam logic [2:0] RP_ACK = 3'd0, RP_NAK = 3'd1, RP_STALL = 3'd2, RP_DATA = 3'd3;
  localparam logic [1:0] ERR_LAST = 2'd2;

  logic rx_rdy, tx_rdy, rx_stall, err, req, stat, nak_to;
  logic busy, cur_in, tog;
  logic [1:0] errcnt;
  logic [NAK_W-1:0] nakcnt;
  logic [NAK_W:0] nak_inc;

  assign csr_rdata = {nak_to, stat, req, err, 1'b0, rx_stall, tx_rdy, rx_rdy};
  assign pe_start  = !busy && (tx_rdy || (stat && req));
  assign pe_in     = busy ? cur_in : !tx_rdy;
  assign pe_data1  = pe_in ? 1'b1 : tog;

  logic fin, good, stall, nak, bad, nak_hit, err_hit, done_txn;
  assign fin      = busy && pe_done;
  assign good     = cur_in ? (pe_reply == RP_DATA) : (pe_reply == RP_ACK);
  assign stall    = pe_reply == RP_STALL;
  assign nak      = pe_reply == RP_NAK;
  assign bad      = !good && !stall && !nak;
  assign nak_inc  = {1'b0, nakcnt} + {{NAK_W{1'b0}}, 1'b1};
  assign nak_hit  = nak && (nak_limit != '0) && (nak_inc >= {1'b0, nak_limit});
  assign err_hit  = bad && (errcnt == ERR_LAST);
  assign done_txn = fin && (good || stall || nak_hit || err_hit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {rx_rdy, tx_rdy, rx_stall, err, req, stat, nak_to} <= '0;
      busy <= 1'b0; cur_in <= 1'b0; tog <= 1'b1; irq <= 1'b0;
      errcnt <= '0; nakcnt <= '0;
    end else begin
      irq <= done_txn;
      if (csr_wr) begin
        rx_rdy   <= rx_rdy & csr_wdata[0];
        tx_rdy   <= csr_wdata[1];
        rx_stall <= rx_stall & csr_wdata[2];
        err      <= err & csr_wdata[4];
        req      <= csr_wdata[5];
        stat     <= csr_wdata[6];
        nak_to   <= nak_to & csr_wdata[7];
        if (csr_wdata[3]) tog <= 1'b1;
      end
      if (pe_start) begin
        busy   <= 1'b1;
        cur_in <= !tx_rdy;
      end
      if (fin) begin
        busy <= 1'b0;
        if (good || stall) begin
          errcnt <= '0;
          nakcnt <= '0;
        end
        if (good && !cur_in) tog <= ~tog;
        if (good && cur_in) rx_rdy <= 1'b1;
        if (stall) rx_stall <= 1'b1;
        if (nak) begin
          errcnt <= '0;
          nakcnt <= nak_hit ? '0 : nak_inc[NAK_W-1:0];
          if (nak_hit) nak_to <= 1'b1;
        end
        if (bad) begin
          nakcnt <= '0;
          errcnt <= err_hit ? '0 : errcnt + 2'd1;
          if (err_hit) err <= 1'b1;
        end
        if (done_txn) begin
          if (cur_in) req <= 1'b0;
          else tx_rdy <= 1'b0;
        end
      end
    end
  end

  // R2
  start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_start |=> !pe_start);
  // R3
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(pe_done));
  // R7
  err_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    errcnt != 2'd3);
  // R7
  err_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> irq);
  // R6
  nak_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nak_to) |-> $past(nak_limit) != '0);
  // R5
  tx_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(tx_rdy) && !$past(csr_wr)) |-> irq);
endmodule

// File: tb/tb_usb_ep0_ctrl_seq.sv
module tb_usb_ep0_ctrl_seq;
  logic clk = 1'b0, rst_n = 1'b0, csr_wr = 1'b0, pe_done = 1'b0;
  logic [7:0] csr_wdata = '0;
  logic [7:0] nak_limit = '0;
  logic [2:0] pe_reply = '0;
  logic [7:0] csr_rdata;
  logic pe_start, pe_in, pe_data1, irq;
  int checks = 0, fails = 0;
  bit done_flag = 0;
  bit exp_tog = 1;

  always #2 clk = ~clk;

  usb_ep0_ctrl_seq #(.NAK_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .nak_limit(nak_limit), .csr_rdata(csr_rdata), .pe_start(pe_start),
    .pe_in(pe_in), .pe_data1(pe_data1), .pe_done(pe_done),
    .pe_reply(pe_reply), .irq(irq));

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] v);
    csr_wr = 1'b1; csr_wdata = v;
    @(negedge clk);
    csr_wr = 1'b0;
  endtask

  task automatic reply(input logic [2:0] c);
    pe_done = 1'b1; pe_reply = c;
    @(negedge clk);
    pe_done = 1'b0;
  endtask

  task automatic arm_out();
    wr(8'h02);
    chk(pe_start, 1, "R2 start");
    chk(pe_in, 0, "R2 token");
    chk(pe_data1, exp_tog, "R4 out pid");
    @(negedge clk);
    chk(pe_start, 0, "R2 single");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(csr_rdata, 8'h00, "R1 reg");
    chk(irq, 0, "R1 irq");
    chk(pe_start, 0, "R1 start");
    chk(pe_data1, 1, "R1 pid");

    // R3 R4 toggle sweep
    for (int k = 0; k < 6; k++) begin
      arm_out();
      reply(3'd0);
      chk(irq, 1, "R3 irq");
      chk(csr_rdata[1], 0, "R3 tx clear");
      chk(pe_start, 0, "R3 no restart");
      exp_tog = ~exp_tog;
      @(negedge clk);
      chk(irq, 0, "R3 pulse");
    end
    arm_out();
    reply(3'd0);
    exp_tog = ~exp_tog;
    wr(8'h08);
    chk(csr_rdata, 8'h00, "R4 bit3 reads 0");
    exp_tog = 1;
    arm_out();
    reply(3'd0);
    exp_tog = 0;

    // R6 NAK limit sweep
    for (int lim = 0; lim < 5; lim++) begin
      nak_limit = 8'(lim);
      arm_out();
      for (int n = 1; n <= 6; n++) begin
        bit hit;
        hit = (lim != 0) && (n == lim);
        reply(3'd1);
        chk(irq, hit, "R6 irq");
        chk(csr_rdata[7], hit, "R6 timeout bit");
        chk(csr_rdata[1], !hit, "R6 tx");
        if (hit) break;
        chk(pe_start, 1, "R6 retry");
        @(negedge clk);
      end
      if (lim == 0) begin
        reply(3'd0);
        exp_tog = ~exp_tog;
      end
      wr(8'h00);
    end

    // R8 NAK count restart on other reply
    nak_limit = 8'd3;
    arm_out();
    for (int i = 0; i < 5; i++) begin
      reply(i == 2 ? 3'd4 : 3'd1);
      chk(irq, 0, "R8 no timeout");
      @(negedge clk);
    end
    reply(3'd1);
    chk(csr_rdata[7], 1, "R8 timeout");
    wr(8'h00);
    nak_limit = 8'd0;

    // R7 error sweep over invalid codes for OUT
    for (int c = 3; c < 8; c++) begin
      arm_out();
      for (int t = 1; t <= 3; t++) begin
        reply(3'(c));
        chk(irq, t == 3, "R7 irq");
        chk(csr_rdata[4], t == 3, "R7 err bit");
        chk(csr_rdata[1], t != 3, "R7 tx");
        if (t != 3) @(negedge clk);
      end
      wr(8'h00);
    end

    // R7 count restarted by NAK
    arm_out();
    for (int i = 0; i < 5; i++) begin
      reply(i == 2 ? 3'd1 : 3'd4);
      chk(csr_rdata[4], 0, "R7 restart");
      @(negedge clk);
    end
    reply(3'd4);
    chk(csr_rdata[4], 1, "R7 third after restart");
    wr(8'h00);

    // R5 STALL on OUT
    arm_out();
    reply(3'd2);
    chk(csr_rdata, 8'h04, "R5 out stall");
    chk(irq, 1, "R5 irq");
    wr(8'h00);

    // R9 IN status stage, R4 pid on IN
    wr(8'h60);
    chk(pe_start, 1, "R9 start");
    chk(pe_in, 1, "R9 token");
    chk(pe_data1, 1, "R4 in pid");
    @(negedge clk);
    reply(3'd3);
    chk(csr_rdata, 8'h41, "R9 data");
    chk(irq, 1, "R9 irq");
    chk(pe_start, 0, "R9 no restart");
    wr(8'h60);
    @(negedge clk);
    reply(3'd2);
    chk(csr_rdata, 8'h44, "R5 in stall");
    wr(8'h60);
    @(negedge clk);
    for (int t = 1; t <= 3; t++) begin
      reply(3'd0);
      chk(csr_rdata[4], t == 3, "R7 ack on in");
      if (t != 3) @(negedge clk);
    end
    chk(csr_rdata, 8'h50, "R7 in error reg");

    // R10 sticky bits
    wr(8'h95);
    chk(csr_rdata, 8'h10, "R10 write one keeps");
    wr(8'h00);
    chk(csr_rdata, 8'h00, "R10 write zero clears");
    nak_limit = 8'd1;
    arm_out();
    csr_wr = 1'b1; csr_wdata = 8'h02;
    reply(3'd1);
    csr_wr = 1'b0;
    chk(csr_rdata, 8'h80, "R10 hw wins");

    done_flag = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule